// File: doc/BRIEF.md
# Per-Bank DRAM Refresh Scheduler

This block decides when a low-power DRAM controller must send refresh commands and to which bank. It runs in one of two modes chosen by a configuration input. In whole-device mode, one refresh is owed every programmed refresh interval, and that refresh takes every bank offline. In single-bank mode, the same interval is split into equal slices, one slice per bank. Each slice credits one refresh to the next bank in a fixed rotation. A single-bank refresh takes only its own bank offline, for a shorter recovery time.

The block keeps a count of refreshes owed per bank, plus one count for whole-device refreshes. It offers a request with a bank address to the command arbiter and completes it on a same-cycle grant. After a grant it raises busy flags for the affected banks until the programmed recovery time has run out, and it will not request a busy bank again during that time. A bank that is not idle is skipped and its refresh is postponed. Once a count reaches the programmed postpone limit, the request is marked urgent and is offered even if the bank is not idle.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `ref_req` and `ref_urgent` are 0 and `bank_busy` is all zeros.
- R2: In whole-device mode (`cfg_per_bank`=0), one refresh is owed every `cfg_trefi` cycles. The first one becomes visible on `ref_req` right after the `cfg_trefi`-th clock edge following reset release.
- R3: In single-bank mode (`cfg_per_bank`=1), one refresh is owed every `cfg_trefi`/8 cycles. The credits go to banks 0,1,…,7 in turn and then wrap to 0. If every bank stays idle and each request is granted at once, the banks are granted in that same order.
- R4: In single-bank mode, a non-urgent request names the first bank, searching upward (with wrap) from the bank after the last one granted, that owes a refresh, is idle and is not busy.
- R5: A bank that owes a refresh but is not idle gets no request. Its debt is kept, and it is served once it becomes idle.
- R6: When a bank's owed count reaches `cfg_postpone` (a nonzero limit), `ref_urgent` is 1 and `ref_bank` names that bank even if it is not idle. An urgent bank takes priority over non-urgent ones.
- R7: A grant in single-bank mode holds `bank_busy` of that bank high for exactly `cfg_trfc_bank` cycles and leaves the other flags unchanged.
- R8: A grant in whole-device mode holds every `bank_busy` flag high for exactly `cfg_trfc_all` cycles. On such a request, `ref_all`=1 and `ref_bank`=0.
- R9: A non-urgent whole-device request is raised only while every bank is idle and no bank is busy.
- R10: Each owed refresh produces exactly one grant. A grant clears one unit of debt, so no request remains once all debt has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_per_bank | input | 1 | 1 = single-bank refresh, 0 = whole-device refresh |
| cfg_trefi | input | 16 | Average refresh interval for the whole device, in cycles |
| cfg_trfc_all | input | 16 | Whole-device refresh recovery time, in cycles |
| cfg_trfc_bank | input | 16 | Single-bank refresh recovery time, in cycles |
| cfg_postpone | input | 4 | Owed count at which a request becomes urgent |
| bank_idle | input | 8 | Per-bank idle (precharged) status |
| ref_gnt | input | 1 | Arbiter accepts the current request this cycle |
| ref_req | output | 1 | Refresh request |
| ref_all | output | 1 | Request is a whole-device refresh |
| ref_bank | output | 3 | Bank to refresh (single-bank mode) |
| ref_urgent | output | 1 | Postpone limit reached; must be granted first |
| bank_busy | output | 8 | Bank is within its refresh recovery time |

## Verification
The hardest situation to reach is an urgent request. It needs one bank to stay non-idle across several full rotations while every other bank keeps being served, so that its debt reaches the limit. The stimulus holds one bank non-idle for three complete rotations with a limit of 3, and grants every other request at once. It then expects the held bank to appear as urgent in the middle of the third rotation, in its rotation slot. A second test leaves one bank non-idle only until the next bank has been served. It expects the deferred bank to be picked out of order, before the following credit arrives.

// File: rtl/rfsh_pkg.sv
// Package: shared types for the refresh scheduler.
// Assumes: the bank count is a power of two, so bank pointers wrap naturally.
package rfsh_pkg;
    typedef enum logic {
        MODE_ALL = 1'b0,
        MODE_PB  = 1'b1
    } rfsh_mode_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: rfsh_interval_timer
// Produces a one-cycle refresh credit pulse. In whole-device mode the period is
// trefi; in single-bank mode it is trefi divided by the bank count. The credited
// bank rotates once per pulse in single-bank mode.
// Assumes: the bank count is 2**BANK_W; a period of zero is treated as one.
module rfsh_interval_timer #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_bank,
    input  logic [CNT_W-1:0]  trefi,
    output logic              tick,
    output logic [BANK_W-1:0] tick_bank
);
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] cnt_q;
    logic [BANK_W-1:0] ptr_q;

    // Pick the period for the current mode and compute its terminal value.
    always_comb begin
        period   = per_bank ? (trefi >> BANK_W) : trefi;
        last_val = (period == '0) ? '0 : period - 1'b1;
        tick     = (cnt_q >= last_val);
    end

    // Count cycles inside one interval; restart on each credit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Move the credited bank forward after each single-bank pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (tick && per_bank) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign tick_bank = ptr_q;
endmodule

// File: rtl/rfsh_debt_ledger.sv
// Module: rfsh_debt_ledger
// Keeps the owed-refresh counts: one per bank for single-bank mode and one for
// whole-device mode. Credits add one, grants take one, and counts saturate at
// both ends. Reports which counts are nonzero and which have reached the limit.
// Assumes: a credit and a grant to the same counter in one cycle cancel.
module rfsh_debt_ledger #(
    parameter int unsigned NB     = 8,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned DEBT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_bank,
    input  logic              tick,
    input  logic [BANK_W-1:0] tick_bank,
    input  logic              grant,
    input  logic              grant_all,
    input  logic [BANK_W-1:0] grant_bank,
    input  logic [DEBT_W-1:0] limit,
    output logic [NB-1:0]     owed_pb,
    output logic [NB-1:0]     urgent_pb,
    output logic              owed_all,
    output logic              urgent_all
);
    localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};

    logic [DEBT_W-1:0] all_q;
    logic              all_inc;
    logic              all_dec;

    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        logic [DEBT_W-1:0] cnt_q;
        logic              inc;
        logic              dec;

        // Decode whether this bank gains or pays off a refresh this cycle.
        always_comb begin
            inc = tick && per_bank && (tick_bank == BANK_W'(gi));
            dec = grant && !grant_all && (grant_bank == BANK_W'(gi));
        end

        // Update the saturating owed count of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                case ({inc, dec})
                    2'b10:   if (cnt_q != DMAX) cnt_q <= cnt_q + 1'b1;
                    2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign owed_pb[gi]   = (cnt_q != '0);
        assign urgent_pb[gi] = (cnt_q != '0) && (cnt_q >= limit);
    end

    // Decode credit and payment for the whole-device count.
    always_comb begin
        all_inc = tick && !per_bank;
        all_dec = grant && grant_all;
    end

    // Update the saturating whole-device owed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_q <= '0;
        end else begin
            case ({all_inc, all_dec})
                2'b10:   if (all_q != DMAX) all_q <= all_q + 1'b1;
                2'b01:   if (all_q != '0)   all_q <= all_q - 1'b1;
                default: all_q <= all_q;
            endcase
        end
    end

    assign owed_all   = (all_q != '0);
    assign urgent_all = (all_q != '0) && (all_q >= limit);
endmodule

// File: rtl/rfsh_bank_picker.sv
// Module: rfsh_bank_picker
// Rotating priority search. Starting at a given bank and wrapping, it returns the
// first urgent candidate if there is one, and otherwise the first normal one.
// Assumes: the bank count is 2**BANK_W, so the index wraps through overflow.
module rfsh_bank_picker #(
    parameter int unsigned NB     = 8,
    parameter int unsigned BANK_W = 3
) (
    input  logic [BANK_W-1:0] start,
    input  logic [NB-1:0]     cand,
    input  logic [NB-1:0]     cand_urg,
    output logic              found,
    output logic              found_urg,
    output logic [BANK_W-1:0] pick
);
    logic              n_hit;
    logic              u_hit;
    logic [BANK_W-1:0] n_idx;
    logic [BANK_W-1:0] u_idx;
    logic [BANK_W-1:0] idx;

    // Scan all banks in rotating order; keep the first hit of each class.
    always_comb begin
        n_hit = 1'b0;
        u_hit = 1'b0;
        n_idx = '0;
        u_idx = '0;
        idx   = '0;
        for (int k = 0; k < NB; k++) begin
            idx = start + BANK_W'(k);
            if (!u_hit && cand_urg[idx]) begin
                u_hit = 1'b1;
                u_idx = idx;
            end
            if (!n_hit && cand[idx]) begin
                n_hit = 1'b1;
                n_idx = idx;
            end
        end
        found     = n_hit || u_hit;
        found_urg = u_hit;
        pick      = u_hit ? u_idx : n_idx;
    end
endmodule

// File: rtl/rfsh_busy_timers.sv
// Module: rfsh_busy_timers
// One down-counter per bank for the refresh recovery time. A whole-device grant
// loads every counter with the long time; a single-bank grant loads one counter
// with the short time. A bank is busy while its counter is nonzero.
// Assumes: the two load strobes are never active together.
module rfsh_busy_timers #(
    parameter int unsigned NB     = 8,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_all,
    input  logic              load_one,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [CNT_W-1:0]  trfc_all,
    input  logic [CNT_W-1:0]  trfc_bank,
    output logic [NB-1:0]     busy
);
    for (genvar gi = 0; gi < NB; gi++) begin : g_tmr
        logic [CNT_W-1:0] cnt_q;

        // Load on grant, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (load_all) begin
                cnt_q <= trfc_all;
            end else if (load_one && (load_bank == BANK_W'(gi))) begin
                cnt_q <= trfc_bank;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign busy[gi] = (cnt_q != '0);
    end
endmodule

// File: rtl/rfsh_sched.sv
// Module: rfsh_sched (top)
// Refresh scheduler for single-bank or whole-device refresh. It combines the
// interval timer, the debt ledger, the rotating picker and the busy timers, and
// offers one request at a time. A request completes when ref_gnt is high in the
// same cycle as ref_req.
// Assumes: the mode and timing inputs are static while refreshes are owed;
// NB is a power of two.
module rfsh_sched #(
    parameter int unsigned NB     = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEBT_W = 4,
    localparam int unsigned BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_per_bank,
    input  logic [CNT_W-1:0]  cfg_trefi,
    input  logic [CNT_W-1:0]  cfg_trfc_all,
    input  logic [CNT_W-1:0]  cfg_trfc_bank,
    input  logic [DEBT_W-1:0] cfg_postpone,
    input  logic [NB-1:0]     bank_idle,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ref_all,
    output logic [BANK_W-1:0] ref_bank,
    output logic              ref_urgent,
    output logic [NB-1:0]     bank_busy
);
    import rfsh_pkg::*;

    rfsh_mode_e        mode;
    logic              pb;
    logic              tick;
    logic [BANK_W-1:0] tick_bank;
    logic [NB-1:0]     owed_pb;
    logic [NB-1:0]     urgent_pb;
    logic              owed_all;
    logic              urgent_all;
    logic [NB-1:0]     cand;
    logic [NB-1:0]     cand_urg;
    logic              pk_found;
    logic              pk_urg;
    logic [BANK_W-1:0] pk_bank;
    logic [BANK_W-1:0] rr_q;
    logic              all_ok;
    logic              grant;

    assign mode = rfsh_mode_e'(cfg_per_bank);
    assign pb   = (mode == MODE_PB);

    rfsh_interval_timer #(
        .CNT_W (CNT_W),
        .BANK_W(BANK_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_bank (pb),
        .trefi    (cfg_trefi),
        .tick     (tick),
        .tick_bank(tick_bank)
    );

    rfsh_debt_ledger #(
        .NB    (NB),
        .BANK_W(BANK_W),
        .DEBT_W(DEBT_W)
    ) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_bank  (pb),
        .tick      (tick),
        .tick_bank (tick_bank),
        .grant     (grant),
        .grant_all (ref_all),
        .grant_bank(ref_bank),
        .limit     (cfg_postpone),
        .owed_pb   (owed_pb),
        .urgent_pb (urgent_pb),
        .owed_all  (owed_all),
        .urgent_all(urgent_all)
    );

    // Form candidate masks: normal banks must be idle, and no bank may be busy.
    always_comb begin
        cand     = owed_pb & bank_idle & ~bank_busy;
        cand_urg = urgent_pb & ~bank_busy;
    end

    rfsh_bank_picker #(
        .NB    (NB),
        .BANK_W(BANK_W)
    ) u_picker (
        .start    (rr_q),
        .cand     (cand),
        .cand_urg (cand_urg),
        .found    (pk_found),
        .found_urg(pk_urg),
        .pick     (pk_bank)
    );

    // Decide the request outputs for the active mode.
    always_comb begin
        all_ok = owed_all && (bank_busy == '0) && ((&bank_idle) || urgent_all);
        if (pb) begin
            ref_req    = pk_found;
            ref_all    = 1'b0;
            ref_bank   = pk_bank;
            ref_urgent = pk_found && pk_urg;
        end else begin
            ref_req    = all_ok;
            ref_all    = 1'b1;
            ref_bank   = '0;
            ref_urgent = all_ok && urgent_all;
        end
        grant = ref_req && ref_gnt;
    end

    // Restart the search at the bank after the one just granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (grant && !ref_all) begin
            rr_q <= ref_bank + 1'b1;
        end
    end

    rfsh_busy_timers #(
        .NB    (NB),
        .BANK_W(BANK_W),
        .CNT_W (CNT_W)
    ) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (grant && ref_all),
        .load_one (grant && !ref_all),
        .load_bank(ref_bank),
        .trfc_all (cfg_trfc_all),
        .trfc_bank(cfg_trfc_bank),
        .busy     (bank_busy)
    );
endmodule

// File: rtl/rfsh_sched_chk.sv
// Module: rfsh_sched_chk
// Checker bound to rfsh_sched. It observes the top-level ports only.
module rfsh_sched_chk #(
    parameter int unsigned NB     = 8,
    parameter int unsigned BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NB-1:0]     bank_idle,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ref_all,
    input logic [BANK_W-1:0] ref_bank,
    input logic              ref_urgent,
    input logic [NB-1:0]     bank_busy
);
    // Flags are all low while reset is held (R1).
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (bank_busy == '0));

    // A normal single-bank request names an idle bank that is not busy (R4).
    assert_pick_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_all && !ref_urgent) |-> (bank_idle[ref_bank] && !bank_busy[ref_bank]));

    // An urgent flag only comes with a request (R6).
    assert_urgent_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    // A single-bank grant makes that bank busy on the next cycle (R7).
    assert_bank_busy_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt && !ref_all) |=> bank_busy[$past(ref_bank)]);

    // A whole-device grant makes every bank busy on the next cycle (R8).
    assert_all_busy_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt && ref_all) |=> (&bank_busy));

    // A normal whole-device request needs every bank idle and none busy (R9).
    assert_all_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_all && !ref_urgent) |-> ((&bank_idle) && (bank_busy == '0)));

    // A busy flag rises only right after a grant (R10).
    assert_busy_rise_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bank_busy & ~$past(bank_busy))) |-> $past(ref_req && ref_gnt));
endmodule

bind rfsh_sched rfsh_sched_chk #(
    .NB    (NB),
    .BANK_W(BANK_W)
) u_rfsh_sched_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_idle (bank_idle),
    .ref_gnt   (ref_gnt),
    .ref_req   (ref_req),
    .ref_all   (ref_all),
    .ref_bank  (ref_bank),
    .ref_urgent(ref_urgent),
    .bank_busy (bank_busy)
);

// File: tb/test_rfsh_sched.sv
// Scoreboard bench for rfsh_sched. The test sequence pushes the expected grants
// into a queue. A monitor grants every request at once, pops the queue and
// compares what it pops with the request it grants.
module test_rfsh_sched;
    localparam int NB = 8;

    typedef struct {
        int bank;
        bit all;
        bit urg;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_per_bank = 1'b0;
    logic [15:0] cfg_trefi = 16'd64;
    logic [15:0] cfg_trfc_all = 16'd7;
    logic [15:0] cfg_trfc_bank = 16'd3;
    logic [3:0]  cfg_postpone = 4'd3;
    logic [7:0]  bank_idle = 8'hFF;
    logic        ref_gnt = 1'b0;
    logic        ref_req;
    logic        ref_all;
    logic [2:0]  ref_bank;
    logic        ref_urgent;
    logic [7:0]  bank_busy;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    gnt_cnt = 0;
    int    first_req_cyc = -1;
    string cur_tag = "R4";
    exp_t  exp_q[$];

    rfsh_sched i_rfsh_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_per_bank (cfg_per_bank),
        .cfg_trefi    (cfg_trefi),
        .cfg_trfc_all (cfg_trfc_all),
        .cfg_trfc_bank(cfg_trfc_bank),
        .cfg_postpone (cfg_postpone),
        .bank_idle    (bank_idle),
        .ref_gnt      (ref_gnt),
        .ref_req      (ref_req),
        .ref_all      (ref_all),
        .ref_bank     (ref_bank),
        .ref_urgent   (ref_urgent),
        .bank_busy    (bank_busy)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic push_exp(input int bank, input bit all, input bit urg);
        exp_t e;
        e.bank = bank;
        e.all  = all;
        e.urg  = urg;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input bit pbm);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_per_bank = pbm;
        bank_idle = 8'hFF;
        exp_q.delete();
        repeat (3) @(negedge clk);
        gnt_cnt = 0;
        first_req_cyc = -1;
        // R1: quiet outputs while and right after reset
        check(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
        check(bank_busy == 8'h00, "R1 bank_busy", int'(bank_busy), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: grant each request at once and score it against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ref_req) begin
                if (first_req_cyc < 0) first_req_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected request bank"}, int'(ref_bank), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(ref_bank) == e.bank, {cur_tag, " bank"}, int'(ref_bank), e.bank);
                    check(ref_all == e.all, {cur_tag, " all flag"}, int'(ref_all), int'(e.all));
                    check(ref_urgent == e.urg, {cur_tag, " urgent flag"}, int'(ref_urgent), int'(e.urg));
                end
                ref_gnt = 1'b1;
                gnt_cnt++;
            end else begin
                ref_gnt = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi;
        int stray;

        // Test 1: whole-device mode, interval and recovery time
        cur_tag = "R8";
        do_reset(1'b0);
        push_exp(0, 1'b1, 1'b0);
        push_exp(0, 1'b1, 1'b0);
        wait (gnt_cnt == 1);
        check(first_req_cyc == 64, "R2 first request cycle", first_req_cyc, 64);
        hi = 0;
        repeat (10) begin
            @(negedge clk);
            if (bank_busy == 8'hFF) hi++;
        end
        check(hi == 7, "R8 all-bank busy cycles", hi, 7);
        bank_idle = 8'hFD;
        wait_cyc(134);
        check(ref_req == 1'b0, "R9 no request with bank 1 active", int'(ref_req), 0);
        bank_idle = 8'hFF;
        wait_cyc(150);
        check(gnt_cnt == 2, "R9 request after banks idle", gnt_cnt, 2);
        check(exp_q.size() == 0, "R10 all-bank queue drained", exp_q.size(), 0);

        // Test 2: single-bank rotation, period and busy window
        cur_tag = "R3";
        cfg_trefi = 16'd64;
        do_reset(1'b1);
        for (int r = 0; r < 9; r++) push_exp(r % NB, 1'b0, 1'b0);
        wait (gnt_cnt == 1);
        check(first_req_cyc == 8, "R3 first request cycle", first_req_cyc, 8);
        hi = 0;
        stray = 0;
        repeat (6) begin
            @(negedge clk);
            if (bank_busy[0]) hi++;
            if ((bank_busy & 8'hFE) != 8'h00) stray++;
        end
        check(hi == 3, "R7 bank busy cycles", hi, 3);
        check(stray == 0, "R7 other banks not busy", stray, 0);
        wait_cyc(76);
        check(gnt_cnt == 9, "R10 one grant per credit", gnt_cnt, 9);
        check(exp_q.size() == 0, "R10 single-bank queue drained", exp_q.size(), 0);
        check(ref_req == 1'b0, "R10 no request left", int'(ref_req), 0);

        // Test 3: deferral of a non-idle bank and out-of-order service
        cur_tag = "R5";
        do_reset(1'b1);
        bank_idle = 8'hFB;
        push_exp(0, 1'b0, 1'b0);
        push_exp(1, 1'b0, 1'b0);
        push_exp(3, 1'b0, 1'b0);
        push_exp(2, 1'b0, 1'b0);
        for (int b = 4; b < NB; b++) push_exp(b, 1'b0, 1'b0);
        wait_cyc(30);
        check(ref_req == 1'b0, "R5 deferred bank 2 not requested", int'(ref_req), 0);
        cur_tag = "R4";
        wait_cyc(36);
        bank_idle = 8'hFF;
        wait_cyc(70);
        check(exp_q.size() == 0, "R4 deferral queue drained", exp_q.size(), 0);

        // Test 4: bank 5 stays active until its debt reaches the limit
        cur_tag = "R6";
        do_reset(1'b1);
        bank_idle = 8'hDF;
        for (int r = 0; r < 2; r++) begin
            for (int b = 0; b < NB; b++) begin
                if (b != 5) push_exp(b, 1'b0, 1'b0);
            end
        end
        for (int b = 0; b < NB; b++) push_exp(b, 1'b0, (b == 5));
        wait_cyc(196);
        check(exp_q.size() == 0, "R6 urgent queue drained", exp_q.size(), 0);
        check(ref_req == 1'b0, "R6 no request below limit", int'(ref_req), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule